// File: doc/BRIEF.md
# Shared Resource Request Arbiter

This block lets several client ports share one resource that answers after a fixed number of cycles, such as a single-port lookup memory or a signed multiplier. Each client places an argument on its own input and raises its request line. It holds the request until the arbiter answers. The arbiter chooses one pending client in rotating order and starts the resource with that client's argument. It waits out the resource latency and then strobes that client's valid line for one cycle. The result is on a bus shared by all clients, and it is good only during that strobe. The client registers it there and then drops its request.

Only one transaction is in flight at any time. With a one-cycle resource, a grant takes three cycles: select, issue and return. For a lookup memory the argument is a 14-bit address (0 to 11999) and the result is a 16-bit word. For a multiplier the argument packs two 18-bit signed operands (ARG_W = 36) and the result is the 36-bit signed product.

Top module: `shared_rsrc_arb`

## Requirements
- R1: After reset no valid line is high and the resource start line is low. When every port requests at once, the first grant goes to port 0.
- R2: A held request produces exactly one valid pulse, one cycle long, on that port's line and on no other line. With RD_LAT = 1, the pulse appears in the third cycle after the request is first driven.
- R3: For a grant, the resource start line is high for exactly one cycle and carries the granted port's argument. The valid pulse comes RD_LAT cycles later, and the shared result bus then carries the resource's answer for that argument.
- R4: Grants rotate round-robin. The next grant goes to the first requesting port after the most recently granted one, in increasing index order, wrapping from NPORT-1 to 0.
- R5: At most one transaction is in flight. The resource is not started again until the previous grant has reached its return cycle. At most one valid line is high in any cycle.
- R6: A request withdrawn before it is granted is dropped: no resource access and no valid pulse. A request withdrawn after its grant still completes its resource access, but it gets no valid pulse.
- R7: A synchronous active-high reset aborts any transaction in flight, so no valid pulse follows it. Reset also returns the rotation so that port 0 is preferred next.
- R8: With no request pending, the resource start line stays low.
- R9: The port count and the latency are parameters. With NPORT = 11 and RD_LAT = 3, all eleven simultaneous requests are served in index order, each with its own correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cl_req_i | input | NPORT | Per-client request, held until that client's valid pulse |
| cl_arg_i | input | NPORT*ARG_W | Per-client argument; port p occupies bits p*ARG_W upward |
| cl_vld_o | output | NPORT | Per-client one-cycle completion strobe |
| cl_res_o | output | RES_W | Shared result bus, good only while a valid line is high |
| rs_go_o | output | 1 | Start strobe to the shared resource |
| rs_arg_o | output | ARG_W | Argument presented to the shared resource |
| rs_res_i | input | RES_W | Resource answer, RD_LAT cycles after the start strobe |

## Verification
The bench first checks that a fresh reset serves port 0 first, then forces a wrap-around after serving port 2 on its own. A pointer that does not rotate, or that restarts from zero, would serve the clients in the wrong order. Requests are withdrawn both just before and just after a grant. A design that latches requests would access the resource or pulse a client that has gone away. A reset during an issue cycle must not leave a stray pulse, and the rotation must restart from port 0 afterwards. An 11-port instance with latency 3 catches an off-by-one in the wait counter, which would return the stale value that the bench's resource model drives between reads.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RETURN
    } sra_state_e;

endpackage

// File: rtl/sra_rr_pick.sv
// Rotating priority selector: first requester strictly after 'last_i'.
module sra_rr_pick #(
    parameter int NPORT = 4,
    parameter int IDX_W = 2
) (
    input  logic [NPORT-1:0] req_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // scan the farthest offset first so that the nearest one wins
        for (int k = NPORT; k >= 1; k--) begin
            int cand;
            cand = int'(last_i) + k;
            if (cand >= NPORT) cand = cand - NPORT;
            if (req_i[cand]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/sra_arg_mux.sv
// Selects one client's argument from the flattened argument bus.
module sra_arg_mux #(
    parameter int NPORT = 4,
    parameter int ARG_W = 14,
    parameter int IDX_W = 2
) (
    input  logic [NPORT*ARG_W-1:0] args_i,
    input  logic [IDX_W-1:0]       sel_i,
    output logic [ARG_W-1:0]       arg_o
);
    always_comb begin
        arg_o = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (sel_i == IDX_W'(i)) arg_o = args_i[i*ARG_W +: ARG_W];
        end
    end
endmodule

// File: rtl/shared_rsrc_arb.sv
module shared_rsrc_arb
    import sra_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int ARG_W  = 14,
    parameter int RES_W  = 16,
    parameter int RD_LAT = 1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [NPORT-1:0]       cl_req_i,
    input  logic [NPORT*ARG_W-1:0] cl_arg_i,
    output logic [NPORT-1:0]       cl_vld_o,
    output logic [RES_W-1:0]       cl_res_o,
    output logic                   rs_go_o,
    output logic [ARG_W-1:0]       rs_arg_o,
    input  logic [RES_W-1:0]       rs_res_i
);
    localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int CNT_W = $clog2(RD_LAT + 1);
    localparam logic [CNT_W-1:0] WAIT_LOAD = (RD_LAT > 1) ? CNT_W'(RD_LAT - 2) : '0;

    typedef struct packed {
        sra_state_e       st;
        logic [IDX_W-1:0] gnt;
        logic [IDX_W-1:0] last;
        logic [ARG_W-1:0] arg;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [ARG_W-1:0] pick_arg;

    sra_rr_pick #(.NPORT(NPORT), .IDX_W(IDX_W)) u_pick (
        .req_i   (cl_req_i),
        .last_i  (r_q.last),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    sra_arg_mux #(.NPORT(NPORT), .ARG_W(ARG_W), .IDX_W(IDX_W)) u_mux (
        .args_i (cl_arg_i),
        .sel_i  (pick_idx),
        .arg_o  (pick_arg)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (pick_found) begin
                    r_d.gnt  = pick_idx;
                    r_d.last = pick_idx;
                    r_d.arg  = pick_arg;
                    r_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                r_d.cnt = WAIT_LOAD;
                r_d.st  = (RD_LAT > 1) ? ST_WAIT : ST_RETURN;
            end
            ST_WAIT: begin
                if (r_q.cnt == '0) r_d.st = ST_RETURN;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_RETURN: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.st   <= ST_IDLE;
            r_q.gnt  <= '0;
            r_q.last <= IDX_W'(NPORT - 1);
            r_q.arg  <= '0;
            r_q.cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rs_go_o  = (r_q.st == ST_ISSUE);
    assign rs_arg_o = r_q.arg;
    assign cl_res_o = rs_res_i;

    for (genvar g = 0; g < NPORT; g++) begin : g_vld
        assign cl_vld_o[g] = (r_q.st == ST_RETURN) && (r_q.gnt == IDX_W'(g)) && cl_req_i[g];
    end
endmodule

// File: rtl/shared_rsrc_arb_chk.sv
module shared_rsrc_arb_chk #(
    parameter int NPORT  = 4,
    parameter int RD_LAT = 1
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [NPORT-1:0] cl_req_i,
    input logic [NPORT-1:0] cl_vld_o,
    input logic             rs_go_o
);
    localparam int SW = $clog2(RD_LAT + 2);
    localparam logic [SW-1:0] SAT = SW'(RD_LAT + 1);

    // cycles since the last start strobe, saturating
    logic [SW-1:0] since_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)              since_q <= SAT;
        else if (rs_go_o)       since_q <= '0;
        else if (since_q < SAT) since_q <= since_q + 1'b1;
    end

    assert_vld_onehot_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(cl_vld_o));
    assert_vld_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cl_vld_o != '0) |=> (cl_vld_o == '0));
    assert_go_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        rs_go_o |=> !rs_go_o);
    assert_vld_latency_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cl_vld_o != '0) |-> (since_q == SW'(RD_LAT - 1)));
    assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        rs_go_o |-> (since_q == SAT));
    assert_vld_has_req_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cl_vld_o & ~cl_req_i) == '0);
    assert_go_after_req_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        rs_go_o |-> ($past(cl_req_i) != '0));
endmodule

bind shared_rsrc_arb shared_rsrc_arb_chk #(.NPORT(NPORT), .RD_LAT(RD_LAT)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cl_req_i (cl_req_i),
    .cl_vld_o (cl_vld_o),
    .rs_go_o  (rs_go_o)
);

// File: tb/shared_rsrc_arb_tb.sv
module shared_rsrc_arb_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    function automatic logic [15:0] word(input logic [13:0] a);
        return {a, 2'b01} ^ 16'h5A3C;
    endfunction

    function automatic logic [13:0] argv(input int p);
        return 14'(1000 * p + 7);
    endfunction

    // ---------------- 4-port, latency 1 instance ----------------
    logic [3:0]  req;
    logic [55:0] args;
    logic [3:0]  vld;
    logic [15:0] res;
    logic        go;
    logic [13:0] rarg;
    logic [15:0] mem_q;

    shared_rsrc_arb u_dut (
        .clk_i(clk), .rst_i(rst), .cl_req_i(req), .cl_arg_i(args),
        .cl_vld_o(vld), .cl_res_o(res), .rs_go_o(go), .rs_arg_o(rarg),
        .rs_res_i(mem_q)
    );

    always_ff @(posedge clk) mem_q <= go ? word(rarg) : 16'hDEAD;

    // ---------------- 11-port, latency 3 instance ----------------
    logic [10:0]  req_b;
    logic [153:0] args_b;
    logic [10:0]  vld_b;
    logic [15:0]  res_b;
    logic         go_b;
    logic [13:0]  rarg_b;
    logic [15:0]  p1, p2, p3;

    shared_rsrc_arb #(.NPORT(11), .RD_LAT(3)) u_dut_big (
        .clk_i(clk), .rst_i(rst), .cl_req_i(req_b), .cl_arg_i(args_b),
        .cl_vld_o(vld_b), .cl_res_o(res_b), .rs_go_o(go_b), .rs_arg_o(rarg_b),
        .rs_res_i(p3)
    );

    always_ff @(posedge clk) begin
        p1 <= go_b ? word(rarg_b) : 16'hDEAD;
        p2 <= p1;
        p3 <= p2;
    end

    int          log_port [0:15];
    logic [15:0] log_data [0:15];
    int          nlog;
    int          ngo;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // runs ncyc cycles, logs valid pulses, and drops each served request
    task automatic collect(input int ncyc);
        nlog = 0;
        ngo  = 0;
        repeat (ncyc) begin
            @(negedge clk);
            if (go) ngo++;
            for (int p = 0; p < 4; p++) begin
                if (vld[p] && nlog < 16) begin
                    log_port[nlog] = p;
                    log_data[nlog] = res;
                    nlog++;
                    req[p] = 1'b0;
                end
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        req_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        chk(vld == 4'b0, "R1 valid after reset", int'(vld), 0);
        chk(go == 1'b0, "R1 start after reset", int'(go), 0);
        collect(5);
        chk(ngo == 0, "R8 no start while idle", ngo, 0);
    endtask

    task automatic t_all_first();
        req = 4'b1111;
        collect(20);
        chk(nlog == 4, "R2 four pulses", nlog, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_port[i] == i, "R1 R4 order from reset", log_port[i], i);
            chk(log_data[i] == word(argv(i)), "R3 result per port", int'(log_data[i]), int'(word(argv(i))));
        end
    endtask

    task automatic t_single();
        req[2] = 1'b1;
        @(negedge clk);
        chk(go == 1'b1, "R3 start strobe", int'(go), 1);
        chk(rarg == argv(2), "R3 start argument", int'(rarg), int'(argv(2)));
        chk(vld == 4'b0, "R2 no early pulse", int'(vld), 0);
        @(negedge clk);
        chk(go == 1'b0, "R3 start one cycle", int'(go), 0);
        chk(vld == 4'b0100, "R2 pulse on port 2 only", int'(vld), 4);
        chk(res == word(argv(2)), "R3 result in pulse cycle", int'(res), int'(word(argv(2))));
        @(negedge clk);
        chk(vld == 4'b0, "R2 pulse one cycle", int'(vld), 0);
        req[2] = 1'b0;
        collect(4);
        chk(nlog == 0, "R2 no second pulse", nlog, 0);
    endtask

    task automatic t_wrap();
        req = 4'b1011;
        collect(20);
        chk(nlog == 3, "R4 three pulses", nlog, 3);
        chk(log_port[0] == 3, "R4 wrap first", log_port[0], 3);
        chk(log_port[1] == 0, "R4 wrap second", log_port[1], 0);
        chk(log_port[2] == 1, "R4 wrap third", log_port[2], 1);
    endtask

    task automatic t_withdraw_before();
        req[0] = 1'b1;
        @(negedge clk);
        req[2] = 1'b1;
        @(negedge clk);
        chk(vld == 4'b0001, "R2 pulse on port 0", int'(vld), 1);
        req[0] = 1'b0;
        req[2] = 1'b0;
        collect(6);
        chk(nlog == 0, "R6 withdrawn port not pulsed", nlog, 0);
        chk(ngo == 0, "R6 withdrawn port not accessed", ngo, 0);
    endtask

    task automatic t_withdraw_after();
        req[3] = 1'b1;
        @(negedge clk);
        chk(go == 1'b1, "R6 access started", int'(go), 1);
        req[3] = 1'b0;
        @(negedge clk);
        chk(vld == 4'b0, "R6 no pulse after withdraw", int'(vld), 0);
        collect(4);
        chk(nlog == 0, "R6 still no pulse", nlog, 0);
    endtask

    task automatic t_reset_mid();
        req[1] = 1'b1;
        collect(6);
        chk(nlog == 1 && log_port[0] == 1, "R4 port 1 served", log_port[0], 1);
        req[2] = 1'b1;
        @(negedge clk);
        chk(go == 1'b1, "R7 port 2 in flight", int'(go), 1);
        rst = 1'b1;
        req[2] = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        collect(5);
        chk(nlog == 0, "R7 no pulse after aborting reset", nlog, 0);
        req = 4'b1001;
        collect(12);
        chk(nlog == 2 && log_port[0] == 0, "R7 rotation restarts at port 0", log_port[0], 0);
    endtask

    task automatic t_big();
        int cnt = 0;
        int bad = 0;
        req_b = '1;
        repeat (80) begin
            @(negedge clk);
            for (int p = 0; p < 11; p++) begin
                if (vld_b[p]) begin
                    if (p != cnt || res_b != word(argv(p))) bad++;
                    cnt++;
                    req_b[p] = 1'b0;
                end
            end
        end
        chk(cnt == 11, "R9 eleven pulses", cnt, 11);
        chk(bad == 0, "R9 order and results", bad, 0);
    endtask

    initial begin
        for (int p = 0; p < 4; p++)  args[p*14 +: 14] = argv(p);
        for (int p = 0; p < 11; p++) args_b[p*14 +: 14] = argv(p);
        do_reset();
        t_reset();
        t_all_first();
        t_single();
        t_wrap();
        t_withdraw_before();
        t_withdraw_after();
        t_reset_mid();
        t_big();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule